// File: doc/BRIEF.md
# SPI Burst Register Access Bridge

This block is an SPI slave that turns framed serial transactions into 32-bit reads and writes on a simple internal request/acknowledge bus. Every transaction, framed by one low period of the active-low chip select, opens with a single 32-bit header word. The header carries a command opcode, a 16-bit starting address and a count of 32-bit data words. The data words follow in the same chip-select window. On a write burst each completed data word from the host becomes one bus write. On a read burst the bridge fetches each word from the bus ahead of time and shifts it out on MISO.

The address advances by four after each word. The valid register space ends at 0x8FFF. Device control registers sit at the bottom, a controller register window starts at 0x1000 and a message RAM window starts at 0x8000. A malformed header, or a word whose address falls past the end of the space, sets a sticky error flag and causes no bus access. The SPI pins are sampled in the system clock domain and are taken to be synchronous to it.

Top module: `spi_reg_bridge`

## Requirements
- R1: The header is the first 32-bit word after chip select falls. Bits 31:24 are the opcode, where 0x61 selects a write burst and 0x41 a read burst. Bits 23:8 are the starting address and bits 7:0 are the number of data words.
- R2: SPI mode 0 with the MSB first. MOSI is sampled on rising SCLK edges and MISO changes only after falling SCLK edges. MISO is 0 throughout the header word and while chip select is high.
- R3: In a write burst, the k-th completed data word (k from 0) causes exactly one bus write of that word to address start+4k, for k below the word count.
- R4: In a read burst, data word k carries the value the bus returned for address start+4k, starting from its first bit. The first word follows straight after the header.
- R5: Data words beyond the declared count cause no bus access. They read back as 0 on MISO.
- R6: An opcode other than 0x61 or 0x41, or a word count of 0, makes the whole transaction cause no bus access, return 0 on MISO and set the error flag.
- R7: A data word whose address is above 0x8FFF causes no bus access and reads back as 0. It sets the error flag, while in-range words of the same burst still complete.
- R8: The error flag, once set, stays at 1 until reset.
- R9: If chip select rises part-way through a word, the partial word is discarded. Bus writes already issued remain, and the next transaction starts with a fresh header.
- R10: A bus request holds its address, direction and write data steady until acknowledged. It drops in the cycle after the acknowledge, so each request is one access.
- R11: After synchronous reset, MISO, the bus request and the error flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host (driven 0 when idle) |
| bus_req | output | 1 | Internal bus access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 16 | Internal bus byte address |
| bus_wdata | output | 32 | Internal bus write data |
| bus_ack | input | 1 | Single-cycle access acknowledge |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| err_flag | output | 1 | Sticky protocol/range error |

## Verification
The assertions take the SPI pins to be synchronous to the system clock and chip select to change only while SCLK is low. They also take bus_ack to be a single-cycle pulse that arrives only while a request is pending, and the first read word of a burst depends on the acknowledge arriving well inside half an SCLK period. The stimulus keeps each SCLK phase eight system clocks long and changes chip select only while SCLK rests low. Its bus responder acknowledges one clock after a request appears and drops the acknowledge at once.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  localparam logic [7:0] OPC_WRITE = 8'h61;
  localparam logic [7:0] OPC_READ  = 8'h41;

  typedef enum logic [1:0] {
    BST_HEADER,
    BST_WRITE,
    BST_READ,
    BST_DISCARD
  } burst_state_e;

endpackage

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [WORD_W-1:0] tx_word,
  output logic              miso,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              tx_load
);
  localparam int BCNT_W = $clog2(WORD_W);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(WORD_W - 1);

  logic              sclk_q;
  logic [BCNT_W-1:0] bit_cnt;
  logic              word_seen;
  logic [WORD_W-1:0] rx_sr;
  logic [WORD_W-1:0] tx_sr;
  logic              rise;
  logic              fall;

  assign rise = sclk & ~sclk_q & ~cs_n;
  assign fall = ~sclk & sclk_q & ~cs_n;
  assign miso = tx_sr[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      bit_cnt   <= '0;
      word_seen <= 1'b0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rx_word   <= '0;
      rx_valid  <= 1'b0;
      tx_load   <= 1'b0;
    end else begin
      sclk_q   <= sclk;
      rx_valid <= 1'b0;
      tx_load  <= 1'b0;
      if (cs_n) begin
        bit_cnt   <= '0;
        word_seen <= 1'b0;
        tx_sr     <= '0;
      end else begin
        if (rise) begin
          rx_sr <= {rx_sr[WORD_W-2:0], mosi};
          if (bit_cnt == LAST_BIT) begin
            bit_cnt   <= '0;
            rx_word   <= {rx_sr[WORD_W-2:0], mosi};
            rx_valid  <= 1'b1;
            word_seen <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (fall) begin
          if (bit_cnt == '0 && word_seen) begin
            tx_sr   <= tx_word;
            tx_load <= 1'b1;
          end else begin
            tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_bus_port.sv
module spi_bus_port #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_we,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WORD_W-1:0] start_wdata,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] done_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [WORD_W-1:0] bus_rdata
);
  assign busy = bus_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req    <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      done       <= 1'b0;
      done_rdata <= '0;
    end else begin
      done <= 1'b0;
      if (bus_req) begin
        if (bus_ack) begin
          bus_req    <= 1'b0;
          done       <= 1'b1;
          done_rdata <= bus_rdata;
        end
      end else if (start) begin
        bus_req   <= 1'b1;
        bus_we    <= start_we;
        bus_addr  <= start_addr;
        bus_wdata <= start_wdata;
      end
    end
  end

endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_bridge_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int OP_W       = 8,
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 8,
  parameter int ADDR_LIMIT = 'h8FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_valid,
  input  logic              tx_load,
  output logic [WORD_W-1:0] tx_word,
  input  logic              bp_busy,
  input  logic              bp_done,
  input  logic [WORD_W-1:0] bp_rdata,
  output logic              bp_start,
  output logic              bp_we,
  output logic [ADDR_W-1:0] bp_addr,
  output logic [WORD_W-1:0] bp_wdata,
  output logic              err
);
  localparam int STEP = WORD_W / 8;
  localparam logic [ADDR_W:0] LIMIT_X = (ADDR_W+1)'(ADDR_LIMIT);
  localparam logic [ADDR_W:0] STEP_X  = (ADDR_W+1)'(STEP);

  burst_state_e      state_q;
  logic [ADDR_W:0]   addr_q;
  logic [LEN_W-1:0]  left_q;
  logic              pend_q;
  logic              rd_wait_q;
  logic [WORD_W-1:0] tx_next_q;
  logic              err_q;

  logic [OP_W-1:0]   hdr_op;
  logic [ADDR_W-1:0] hdr_addr;
  logic [LEN_W-1:0]  hdr_len;
  logic              hdr_ok;
  logic              in_range;
  logic              wr_fire;
  logic              rd_fire;

  assign hdr_op   = rx_word[WORD_W-1 -: OP_W];
  assign hdr_addr = rx_word[LEN_W +: ADDR_W];
  assign hdr_len  = rx_word[LEN_W-1:0];
  assign hdr_ok   = (hdr_len != '0) &&
                    (hdr_op == OP_W'(OPC_WRITE) || hdr_op == OP_W'(OPC_READ));
  assign in_range = (addr_q <= LIMIT_X);

  assign wr_fire  = (state_q == BST_WRITE) && rx_valid && (left_q != '0);
  assign rd_fire  = (state_q == BST_READ) && pend_q && !bp_busy && !rd_wait_q;

  assign bp_start = (wr_fire || rd_fire) && in_range;
  assign bp_we    = (state_q == BST_WRITE);
  assign bp_addr  = addr_q[ADDR_W-1:0];
  assign bp_wdata = rx_word;
  assign tx_word  = tx_next_q;
  assign err      = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= BST_HEADER;
      addr_q    <= '0;
      left_q    <= '0;
      pend_q    <= 1'b0;
      rd_wait_q <= 1'b0;
      tx_next_q <= '0;
      err_q     <= 1'b0;
    end else if (cs_n) begin
      state_q   <= BST_HEADER;
      left_q    <= '0;
      pend_q    <= 1'b0;
      rd_wait_q <= 1'b0;
      tx_next_q <= '0;
    end else begin
      if (rx_valid && state_q == BST_HEADER) begin
        addr_q <= {1'b0, hdr_addr};
        left_q <= hdr_len;
        if (!hdr_ok) begin
          state_q <= BST_DISCARD;
          err_q   <= 1'b1;
        end else if (hdr_op == OP_W'(OPC_WRITE)) begin
          state_q <= BST_WRITE;
        end else begin
          state_q <= BST_READ;
          pend_q  <= 1'b1;
        end
      end
      if (wr_fire) begin
        left_q <= left_q - 1'b1;
        addr_q <= addr_q + STEP_X;
        if (!in_range) err_q <= 1'b1;
      end
      if (tx_load) begin
        tx_next_q <= '0;
        if (state_q == BST_READ && left_q != '0) pend_q <= 1'b1;
      end
      if (rd_fire) begin
        pend_q <= 1'b0;
        left_q <= left_q - 1'b1;
        addr_q <= addr_q + STEP_X;
        if (in_range) rd_wait_q <= 1'b1;
        else          err_q     <= 1'b1;
      end
      if (bp_done && rd_wait_q) begin
        tx_next_q <= bp_rdata;
        rd_wait_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge #(
  parameter int WORD_W     = 32,
  parameter int OP_W       = 8,
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 8,
  parameter int ADDR_LIMIT = 'h8FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              err_flag
);
  logic [WORD_W-1:0] rx_word;
  logic              rx_valid;
  logic              tx_load;
  logic [WORD_W-1:0] tx_word;
  logic              bp_start;
  logic              bp_we;
  logic [ADDR_W-1:0] bp_addr;
  logic [WORD_W-1:0] bp_wdata;
  logic              bp_busy;
  logic              bp_done;
  logic [WORD_W-1:0] bp_rdata;

  spi_word_shifter #(.WORD_W(WORD_W)) shifter_i (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_word(tx_word), .miso(spi_miso), .rx_word(rx_word),
    .rx_valid(rx_valid), .tx_load(tx_load)
  );

  spi_burst_ctrl #(
    .WORD_W(WORD_W), .OP_W(OP_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .ADDR_LIMIT(ADDR_LIMIT)
  ) ctrl_i (
    .clk(clk), .rst(rst), .cs_n(spi_cs_n), .rx_word(rx_word),
    .rx_valid(rx_valid), .tx_load(tx_load), .tx_word(tx_word),
    .bp_busy(bp_busy), .bp_done(bp_done), .bp_rdata(bp_rdata),
    .bp_start(bp_start), .bp_we(bp_we), .bp_addr(bp_addr),
    .bp_wdata(bp_wdata), .err(err_flag)
  );

  spi_bus_port #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) port_i (
    .clk(clk), .rst(rst), .start(bp_start), .start_we(bp_we),
    .start_addr(bp_addr), .start_wdata(bp_wdata), .busy(bp_busy),
    .done(bp_done), .done_rdata(bp_rdata), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

endmodule

// File: rtl/spi_reg_bridge_chk.sv
module spi_reg_bridge_chk #(
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int ADDR_LIMIT = 'h8FFF
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_sclk,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              err_flag
);
  // R10: request held steady until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R10: one access per request
  p_req_drop_r10: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req);

  // R7: no access past the end of the space
  p_range_r7: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> ({1'b0, bus_addr} <= (ADDR_W+1)'(ADDR_LIMIT)));

  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  // R2: MISO quiet while deselected
  p_miso_idle_r2: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n && $past(spi_cs_n) |-> !spi_miso);

  // R2: MISO changes only after SCLK has fallen
  p_miso_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && !$past(spi_cs_n) && (spi_miso != $past(spi_miso))) |-> !$past(spi_sclk));

endmodule

bind spi_reg_bridge spi_reg_bridge_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .ADDR_LIMIT(ADDR_LIMIT)
) chk_i (
  .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .spi_miso(spi_miso), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .err_flag(err_flag)
);

// File: tb/spi_reg_bridge_tb_top.sv
module spi_reg_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic        bus_req;
  logic        bus_we;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        err_flag;

  int checks = 0;
  int errors = 0;
  int acc_cnt = 0;
  int wr_cnt = 0;
  logic [31:0] mem [logic [15:0]];
  logic [31:0] tx_words [8];
  logic [31:0] rx_words [8];
  logic prev_cs = 1'b1;
  logic prev_err = 1'b0;

  always #4 clk = ~clk;

  spi_reg_bridge dut_i (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .err_flag(err_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_model(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : (32'hC0DE0000 ^ {16'h0, a});
  endfunction

  // bus responder model plus per-clock protocol checks
  always @(negedge clk) begin
    if (bus_req && !bus_ack && !rst) begin
      acc_cnt++;
      chk(bus_addr <= 16'h8FFF, "R7 bus address range", {16'h0, bus_addr}, 32'h8FFF);
      if (bus_we) begin
        wr_cnt++;
        mem[bus_addr] = bus_wdata;
      end else begin
        bus_rdata = rd_model(bus_addr);
      end
      bus_ack = 1'b1;
    end else begin
      bus_ack = 1'b0;
    end
    if (!rst && cs_n && prev_cs)
      chk(miso == 1'b0, "R2 MISO idle", {31'h0, miso}, 32'h0);
    if (!rst && prev_err)
      chk(err_flag == 1'b1, "R8 sticky error", {31'h0, err_flag}, 32'h1);
    prev_cs  = cs_n;
    prev_err = rst ? 1'b0 : err_flag;
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    prev_err = 1'b0;
    @(negedge clk);
  endtask

  task automatic spi_xfer(input int nbits);
    for (int w = 0; w < 8; w++) rx_words[w] = 'x;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      mosi = tx_words[b / 32][31 - (b % 32)];
      repeat (8) @(negedge clk);
      rx_words[b / 32][31 - (b % 32)] = miso;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [31:0] hdr(input logic [7:0] op, input logic [15:0] a, input logic [7:0] n);
    return {op, a, n};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a0;
    int w0;
    do_reset();
    // R11: reset state
    chk(miso == 1'b0, "R11 miso after reset", {31'h0, miso}, 32'h0);
    chk(bus_req == 1'b0, "R11 bus_req after reset", {31'h0, bus_req}, 32'h0);
    chk(err_flag == 1'b0, "R11 err after reset", {31'h0, err_flag}, 32'h0);

    // R1 R3: write burst of three words at 0x1000
    tx_words[0] = hdr(8'h61, 16'h1000, 8'd3);
    tx_words[1] = 32'hA1A1_0001;
    tx_words[2] = 32'hB2B2_0002;
    tx_words[3] = 32'hC3C3_0003;
    w0 = wr_cnt;
    spi_xfer(4 * 32);
    chk(wr_cnt - w0 == 3, "R3 write count", wr_cnt - w0, 3);
    chk(rd_model(16'h1000) == 32'hA1A1_0001, "R1 R3 word0", rd_model(16'h1000), 32'hA1A1_0001);
    chk(rd_model(16'h1004) == 32'hB2B2_0002, "R3 word1", rd_model(16'h1004), 32'hB2B2_0002);
    chk(rd_model(16'h1008) == 32'hC3C3_0003, "R3 word2", rd_model(16'h1008), 32'hC3C3_0003);

    // R4 R2: read burst back
    tx_words[0] = hdr(8'h41, 16'h1000, 8'd3);
    for (int i = 1; i < 4; i++) tx_words[i] = 32'hFFFF_FFFF;
    spi_xfer(4 * 32);
    chk(rx_words[0] == 32'h0, "R2 header MISO zero", rx_words[0], 32'h0);
    chk(rx_words[1] == 32'hA1A1_0001, "R4 read word0", rx_words[1], 32'hA1A1_0001);
    chk(rx_words[2] == 32'hB2B2_0002, "R4 read word1", rx_words[2], 32'hB2B2_0002);
    chk(rx_words[3] == 32'hC3C3_0003, "R4 read word2", rx_words[3], 32'hC3C3_0003);

    // R4 R5: read of an unwritten address, extra words return zero
    tx_words[0] = hdr(8'h41, 16'h0010, 8'd1);
    a0 = acc_cnt;
    spi_xfer(3 * 32);
    chk(rx_words[1] == rd_model(16'h0010), "R4 single read", rx_words[1], rd_model(16'h0010));
    chk(rx_words[2] == 32'h0, "R5 read beyond count", rx_words[2], 32'h0);
    chk(acc_cnt - a0 == 1, "R5 read access count", acc_cnt - a0, 1);

    // R5: write beyond count ignored
    tx_words[0] = hdr(8'h61, 16'h0020, 8'd1);
    tx_words[1] = 32'h1234_5678;
    tx_words[2] = 32'h8765_4321;
    w0 = wr_cnt;
    spi_xfer(3 * 32);
    chk(wr_cnt - w0 == 1, "R5 write beyond count", wr_cnt - w0, 1);
    chk(rd_model(16'h0020) == 32'h1234_5678, "R5 written word", rd_model(16'h0020), 32'h1234_5678);
    chk(!mem.exists(16'h0024), "R5 no second write", 32'h0, 32'h0);

    // R9: abort part-way through second data word
    tx_words[0] = hdr(8'h61, 16'h0040, 8'd3);
    tx_words[1] = 32'h5555_AAAA;
    tx_words[2] = 32'h6666_BBBB;
    w0 = wr_cnt;
    spi_xfer(2 * 32 + 10);
    chk(wr_cnt - w0 == 1, "R9 abort write count", wr_cnt - w0, 1);
    chk(!mem.exists(16'h0044), "R9 partial word dropped", 32'h0, 32'h0);
    tx_words[0] = hdr(8'h41, 16'h0040, 8'd1);
    spi_xfer(2 * 32);
    chk(rx_words[1] == 32'h5555_AAAA, "R9 fresh header after abort", rx_words[1], 32'h5555_AAAA);
    chk(err_flag == 1'b0, "R9 no error from abort", {31'h0, err_flag}, 32'h0);

    // R6: unknown opcode
    tx_words[0] = hdr(8'h55, 16'h0010, 8'd1);
    tx_words[1] = 32'hDEAD_BEEF;
    a0 = acc_cnt;
    spi_xfer(2 * 32);
    chk(acc_cnt - a0 == 0, "R6 bad opcode no access", acc_cnt - a0, 0);
    chk(rx_words[1] == 32'h0, "R6 bad opcode reads zero", rx_words[1], 32'h0);
    chk(err_flag == 1'b1, "R6 bad opcode error", {31'h0, err_flag}, 32'h1);

    // R8: still set after a clean transaction, cleared by reset
    tx_words[0] = hdr(8'h41, 16'h1000, 8'd1);
    spi_xfer(2 * 32);
    chk(err_flag == 1'b1, "R8 error persists", {31'h0, err_flag}, 32'h1);
    do_reset();
    chk(err_flag == 1'b0, "R8 R11 cleared by reset", {31'h0, err_flag}, 32'h0);

    // R6: zero word count
    tx_words[0] = hdr(8'h41, 16'h1000, 8'd0);
    a0 = acc_cnt;
    spi_xfer(2 * 32);
    chk(acc_cnt - a0 == 0, "R6 zero count no access", acc_cnt - a0, 0);
    chk(rx_words[1] == 32'h0, "R6 zero count reads zero", rx_words[1], 32'h0);
    chk(err_flag == 1'b1, "R6 zero count error", {31'h0, err_flag}, 32'h1);
    do_reset();

    // R7: write burst running past the end of the space
    tx_words[0] = hdr(8'h61, 16'h8FF8, 8'd3);
    tx_words[1] = 32'h0000_8FF8;
    tx_words[2] = 32'h0000_8FFC;
    tx_words[3] = 32'h0000_9000;
    w0 = wr_cnt;
    spi_xfer(4 * 32);
    chk(wr_cnt - w0 == 2, "R7 in-range writes only", wr_cnt - w0, 2);
    chk(rd_model(16'h8FFC) == 32'h0000_8FFC, "R7 last valid word", rd_model(16'h8FFC), 32'h0000_8FFC);
    chk(err_flag == 1'b1, "R7 range error", {31'h0, err_flag}, 32'h1);
    do_reset();

    // R7 R4: read across the end of the space
    tx_words[0] = hdr(8'h41, 16'h8FFC, 8'd2);
    a0 = acc_cnt;
    spi_xfer(3 * 32);
    chk(rx_words[1] == 32'h0000_8FFC, "R4 R7 last valid read", rx_words[1], 32'h0000_8FFC);
    chk(rx_words[2] == 32'h0, "R7 out-of-range read zero", rx_words[2], 32'h0);
    chk(acc_cnt - a0 == 1, "R7 read access count", acc_cnt - a0, 1);
    chk(err_flag == 1'b1, "R7 read range error", {31'h0, err_flag}, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule